// File: doc/BRIEF.md
# Time-of-Day Counter with Merged Set Buttons

This block keeps the time of day as seconds, minutes and hours in two-digit BCD. It runs from a fast system clock and a one-cycle enable pulse that arrives once per second. Seconds count on every such pulse. When seconds wrap from 59 to 00, a carry level goes high and stays high until the next one-second pulse. The minutes stage advances when that carry falls. Minutes and hours are linked in the same way.

Two raw active-high pushbuttons set the time, one for minutes and one for hours. Each button is synchronised and debounced. It is then combined with its stage's incoming carry by an exclusive-OR. The stage steps on every high-to-low transition of that combined level, and that transition is found by comparing the current value with the one from the previous clock. When the button is idle, the carry reaches the stage unchanged.

With the carry low, a press steps the stage when the button is released. With the carry high, it steps the stage when the button is pressed. In both cases each press-and-release gives exactly one step. No derived signal is ever used as a clock.

Top module: `tod_set_counter`

## Requirements
- R1: A synchronous reset sets all three outputs to BCD 00 on the next clock edge.
- R2: Seconds advance by one on each clock where `tick_i` is high, count 00 to 59 in BCD (high nibble tens, low nibble units), and wrap from 59 to 00.
- R3: A seconds wrap raises the minutes carry level. It stays high until the next `tick_i`, so minutes do not change at the wrap itself and advance one clock after that next tick.
- R4: A stage changes only on a high-to-low transition of (incoming carry XOR debounced button). With the button idle, the carry passes through unchanged and the minutes follow the seconds.
- R5: Pressing a set button while its carry is low does not change the stage while the button is held. Releasing it advances the stage by one.
- R6: Pressing a set button while its carry is high advances the stage by one on the press. Releasing it causes no further step.
- R7: Repeated press-and-release cycles advance the stage by exactly one per cycle.
- R8: A raw button pulse shorter than `DEBOUNCE_CYCLES` clocks is ignored. A level held at least that long is accepted.
- R9: Minutes count 00 to 59 in BCD. A minutes wrap, whether from the carry or from the button, raises the hours carry level until the next `tick_i`, and the hours advance then.
- R10: Hours count 00 to 23 in BCD and wrap from 23 to 00.
- R11: The hours set button merges with the hours carry in the same way as the minutes button does with the minutes carry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_i | input | 1 | Synchronous active-high reset |
| tick_i | input | 1 | One-cycle pulse, once per second |
| set_min_i | input | 1 | Raw minutes set button, active high |
| set_hr_i | input | 1 | Raw hours set button, active high |
| sec_bcd_o | output | 8 | Seconds, BCD tens in [7:4], units in [3:0] |
| min_bcd_o | output | 8 | Minutes, BCD tens in [7:4], units in [3:0] |
| hr_bcd_o | output | 8 | Hours, BCD tens in [7:4], units in [3:0] |

## Verification
Seconds change on the clock edge that samples `tick_i`. A carried minute or hour appears one edge after the tick that drops the carry. A raw button change reaches the debounced level `DEBOUNCE_CYCLES`+1 edges after it is first sampled, and any step it causes follows one edge later. The directed checks therefore sample on a falling clock edge only after a wait of three settle intervals for buttons, or several cycles for ticks, so that every pending step has landed. The random phase compares the outputs at every 25th falling edge with a bench model that applies the same latencies cycle by cycle.

// File: rtl/tod_pkg.sv
package tod_pkg;
  typedef logic [7:0] bcd2_t;
  localparam int unsigned SEC_LAST = 59;
  localparam int unsigned MIN_LAST = 59;
  localparam int unsigned HR_LAST  = 23;
endpackage

// File: rtl/tod_btn_filter.sv
module tod_btn_filter #(
  parameter int unsigned SETTLE = 8
) (
  input  logic clk_i,
  input  logic rst_i,
  input  logic raw_i,
  output logic level_o
);
  localparam int unsigned CW = (SETTLE > 1) ? $clog2(SETTLE) : 1;
  localparam logic [CW-1:0] CNT_LAST = CW'(SETTLE - 1);

  logic [1:0]    sync_q;
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      sync_q  <= '0;
      cnt_q   <= '0;
      level_o <= 1'b0;
    end else begin
      sync_q <= {sync_q[0], raw_i};
      if (sync_q[1] == level_o) begin
        cnt_q <= '0;
      end else if (cnt_q == CNT_LAST) begin
        level_o <= sync_q[1];
        cnt_q   <= '0;
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  // R8: the filtered level only ever takes a value the synchroniser presented
  a_r8_accept_settled: assert property (@(posedge clk_i) disable iff (rst_i)
    !$stable(level_o) |-> (level_o == $past(sync_q[1])));
endmodule

// File: rtl/tod_merge_fall.sv
module tod_merge_fall (
  input  logic clk_i,
  input  logic rst_i,
  input  logic carry_i,
  input  logic btn_i,
  output logic step_o
);
  logic adv, adv_q;

  assign adv = carry_i ^ btn_i;

  always_ff @(posedge clk_i) begin
    if (rst_i) adv_q <= 1'b0;
    else       adv_q <= adv;
  end

  assign step_o = adv_q & ~adv;

  // R7: one falling transition gives one step, never two back to back
  a_r7_single_step: assert property (@(posedge clk_i) disable iff (rst_i)
    step_o |=> !step_o);
endmodule

// File: rtl/tod_bcd_stage.sv
module tod_bcd_stage #(
  parameter int unsigned LAST = 59
) (
  input  logic       clk_i,
  input  logic       rst_i,
  input  logic       step_i,
  output logic [7:0] bcd_o,
  output logic       wrap_o
);
  localparam logic [3:0] LAST_T = 4'(LAST / 10);
  localparam logic [3:0] LAST_U = 4'(LAST % 10);

  logic at_last;
  assign at_last = (bcd_o[7:4] == LAST_T) && (bcd_o[3:0] == LAST_U);
  assign wrap_o  = step_i & at_last;

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      bcd_o <= '0;
    end else if (step_i) begin
      if (at_last)                bcd_o <= '0;
      else if (bcd_o[3:0] == 4'd9) bcd_o <= {bcd_o[7:4] + 4'd1, 4'd0};
      else                        bcd_o[3:0] <= bcd_o[3:0] + 4'd1;
    end
  end

  // R2 / R9 / R10: value stays a legal BCD count within the stage's range
  a_r2_bcd_range: assert property (@(posedge clk_i) disable iff (rst_i)
    (bcd_o[3:0] <= 4'd9) &&
    ((int'(bcd_o[7:4]) * 10 + int'(bcd_o[3:0])) <= int'(LAST)));
  // R2: a step below the last value always moves the count
  a_r2_step_moves: assert property (@(posedge clk_i) disable iff (rst_i)
    (step_i && !at_last) |=> (bcd_o != $past(bcd_o)));
endmodule

// File: rtl/tod_set_counter.sv
module tod_set_counter
  import tod_pkg::*;
#(
  parameter int unsigned DEBOUNCE_CYCLES = 1_250_000
) (
  input  logic       clk_i,
  input  logic       rst_i,
  input  logic       tick_i,
  input  logic       set_min_i,
  input  logic       set_hr_i,
  output logic [7:0] sec_bcd_o,
  output logic [7:0] min_bcd_o,
  output logic [7:0] hr_bcd_o
);
  logic  min_btn, hr_btn;
  logic  sec_wrap, min_wrap, hr_wrap;
  logic  min_step, hr_step;
  logic  carry_s_q, carry_m_q;
  bcd2_t sec_v, min_v, hr_v;

  tod_btn_filter #(.SETTLE(DEBOUNCE_CYCLES)) u_flt_min (
    .clk_i(clk_i), .rst_i(rst_i), .raw_i(set_min_i), .level_o(min_btn));
  tod_btn_filter #(.SETTLE(DEBOUNCE_CYCLES)) u_flt_hr (
    .clk_i(clk_i), .rst_i(rst_i), .raw_i(set_hr_i), .level_o(hr_btn));

  tod_bcd_stage #(.LAST(SEC_LAST)) u_sec (
    .clk_i(clk_i), .rst_i(rst_i), .step_i(tick_i), .bcd_o(sec_v), .wrap_o(sec_wrap));

  // seconds carry: set by the wrapping tick, dropped by the following tick
  always_ff @(posedge clk_i) begin
    if (rst_i)       carry_s_q <= 1'b0;
    else if (tick_i) carry_s_q <= sec_wrap;
  end

  tod_merge_fall u_mrg_min (
    .clk_i(clk_i), .rst_i(rst_i), .carry_i(carry_s_q), .btn_i(min_btn), .step_o(min_step));
  tod_bcd_stage #(.LAST(MIN_LAST)) u_min (
    .clk_i(clk_i), .rst_i(rst_i), .step_i(min_step), .bcd_o(min_v), .wrap_o(min_wrap));

  // minutes carry: raised by any minutes wrap, dropped by the next tick
  always_ff @(posedge clk_i) begin
    if (rst_i)         carry_m_q <= 1'b0;
    else if (min_wrap) carry_m_q <= 1'b1;
    else if (tick_i)   carry_m_q <= 1'b0;
  end

  tod_merge_fall u_mrg_hr (
    .clk_i(clk_i), .rst_i(rst_i), .carry_i(carry_m_q), .btn_i(hr_btn), .step_o(hr_step));
  tod_bcd_stage #(.LAST(HR_LAST)) u_hr (
    .clk_i(clk_i), .rst_i(rst_i), .step_i(hr_step), .bcd_o(hr_v), .wrap_o(hr_wrap));

  assign sec_bcd_o = sec_v;
  assign min_bcd_o = min_v;
  assign hr_bcd_o  = hr_v;

  // R1: reset clears every digit on the next edge
  a_r1_reset_clear: assert property (@(posedge clk_i)
    rst_i |=> (sec_bcd_o == 8'h00 && min_bcd_o == 8'h00 && hr_bcd_o == 8'h00));
  // R3: the seconds carry rises only together with seconds reading 00
  a_r3_carry_at_wrap: assert property (@(posedge clk_i) disable iff (rst_i)
    $rose(carry_s_q) |-> (sec_bcd_o == 8'h00));
  // R4: minutes change only after a detected falling transition
  a_r4_min_on_fall: assert property (@(posedge clk_i) disable iff (rst_i)
    !$stable(min_bcd_o) |-> $past(min_step));
  // R11: hours change only after a detected falling transition
  a_r11_hr_on_fall: assert property (@(posedge clk_i) disable iff (rst_i)
    !$stable(hr_bcd_o) |-> $past(hr_step));
  // R10: stepping past 23 lands on 00
  a_r10_hr_wrap: assert property (@(posedge clk_i) disable iff (rst_i)
    hr_wrap |=> (hr_bcd_o == 8'h00));
endmodule

// File: tb/tod_set_counter_tb.sv
module tod_set_counter_tb;
  localparam int DB = 8;

  logic clk = 1'b0, rst = 1'b1, tick = 1'b0, bmin = 1'b0, bhr = 1'b0;
  logic [7:0] sec_o, min_o, hr_o;
  int n_chk = 0, n_fail = 0;
  bit done = 0;

  always #4 clk = ~clk;

  tod_set_counter #(.DEBOUNCE_CYCLES(DB)) u_dut (
    .clk_i(clk), .rst_i(rst), .tick_i(tick), .set_min_i(bmin), .set_hr_i(bhr),
    .sec_bcd_o(sec_o), .min_bcd_o(min_o), .hr_bcd_o(hr_o));

  function automatic logic [7:0] to_bcd(int v);
    return 8'(((v / 10) << 4) | (v % 10));
  endfunction

  // cycle model built from the requirements
  int m_sec, m_min, m_hr;
  bit m_cs, m_cm, m_aqm, m_aqh, m_dbm, m_dbh;
  logic [DB:0] hm, hh;

  always @(posedge clk) begin
    bit am, ah, sm, sh;
    if (rst) begin
      m_sec <= 0; m_min <= 0; m_hr <= 0; m_cs <= 0; m_cm <= 0;
      m_aqm <= 0; m_aqh <= 0; m_dbm <= 0; m_dbh <= 0; hm <= '0; hh <= '0;
    end else begin
      hm <= {hm[DB-1:0], bmin};
      hh <= {hh[DB-1:0], bhr};
      if (&(hm[DB:1] ^ {DB{m_dbm}})) m_dbm <= ~m_dbm;
      if (&(hh[DB:1] ^ {DB{m_dbh}})) m_dbh <= ~m_dbh;
      am = m_cs ^ m_dbm; sm = m_aqm & ~am; m_aqm <= am;
      ah = m_cm ^ m_dbh; sh = m_aqh & ~ah; m_aqh <= ah;
      if (tick) begin m_sec <= (m_sec + 1) % 60; m_cs <= (m_sec == 59); end
      if (sm) m_min <= (m_min + 1) % 60;
      if (sm && m_min == 59) m_cm <= 1'b1;
      else if (tick)         m_cm <= 1'b0;
      if (sh) m_hr <= (m_hr + 1) % 24;
    end
  end

  task automatic chk(string tag, logic [7:0] act, logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic tick1();
    @(negedge clk); tick = 1'b1;
    @(negedge clk); tick = 1'b0;
    @(negedge clk);
  endtask

  task automatic press_min();
    bmin = 1'b1; idle(3 * DB); bmin = 1'b0; idle(3 * DB);
  endtask

  task automatic press_hr();
    bhr = 1'b1; idle(3 * DB); bhr = 1'b0; idle(3 * DB);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    int hold_m, hold_h;
    void'($urandom(32'd4711));
    idle(5); rst = 1'b0; idle(1);
    chk("R1 reset sec", sec_o, 8'h00);
    chk("R1 reset min", min_o, 8'h00);
    chk("R1 reset hr", hr_o, 8'h00);

    bmin = 1'b1; idle(3 * DB);
    chk("R5 held press carry low", min_o, 8'h00);
    bmin = 1'b0; idle(3 * DB);
    chk("R5 step on release", min_o, 8'h01);
    press_min(); press_min();
    chk("R7 two presses", min_o, 8'h03);

    bmin = 1'b1; idle(DB / 2); bmin = 1'b0; idle(3 * DB);
    chk("R8 short pulse ignored", min_o, 8'h03);

    repeat (59) tick1();
    chk("R2 seconds at 59", sec_o, 8'h59);
    tick1(); idle(5);
    chk("R2 seconds wrap", sec_o, 8'h00);
    chk("R3 no minute at wrap", min_o, 8'h03);
    bmin = 1'b1; idle(3 * DB);
    chk("R6 step on press carry high", min_o, 8'h04);
    bmin = 1'b0; idle(3 * DB);
    chk("R6 no step on release", min_o, 8'h04);
    tick1(); idle(5);
    chk("R3 R4 carry falls on next tick", min_o, 8'h05);
    chk("R2 seconds after tick", sec_o, 8'h01);

    repeat (54) press_min();
    chk("R7 minutes stepped to 59", min_o, 8'h59);
    press_min();
    chk("R9 minutes wrap", min_o, 8'h00);
    chk("R9 hours wait for tick", hr_o, 8'h00);
    tick1(); idle(5);
    chk("R9 hours carried", hr_o, 8'h01);

    repeat (22) press_hr();
    chk("R11 hours set to 23", hr_o, 8'h23);
    press_hr();
    chk("R10 hours wrap", hr_o, 8'h00);
    chk("R4 model after directed", min_o, to_bcd(m_min));

    hold_m = 0; hold_h = 0;
    for (int i = 0; i < 4000; i++) begin
      @(negedge clk);
      if (i % 25 == 0) begin
        chk("R2 model seconds", sec_o, to_bcd(m_sec));
        chk("R4 model minutes", min_o, to_bcd(m_min));
        chk("R11 model hours", hr_o, to_bcd(m_hr));
      end
      tick = ($urandom_range(0, 4) == 0);
      if (hold_m == 0) begin
        if ($urandom_range(0, 2) == 0) bmin = ~bmin;
        hold_m = DB + 3 + int'($urandom_range(0, 20));
      end else hold_m--;
      if (hold_h == 0) begin
        if ($urandom_range(0, 2) == 0) bhr = ~bhr;
        hold_h = DB + 3 + int'($urandom_range(0, 20));
      end else hold_h--;
    end
    tick = 1'b0;

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule